// File: doc/BRIEF.md
# UART Baud Tick Generator with Prescaler Select

This block produces the 16x oversampling enable for the transmitter and receiver of a 16550-style serial port. It runs on a fixed 7.3728 MHz reference clock. A 16-bit divisor is loaded one byte at a time. The low 15 bits of that divisor set the division ratio. Bit 15 does not count. It picks the prescaler that sits in front of the divider.

The prescaler divides the reference by four. It is bypassed only when bit 15 is set and the separate high-speed enable input is also high. With the prescaler in use, a ratio of 1 gives a tick every 4 clocks, which is 115200 baud. With the prescaler bypassed, the same ratio gives a tick on every clock, which is 460800 baud. A ratio of zero stops the tick. Each byte write restarts the count, so the new rate starts cleanly from the write.

Top module: `baud_tick_gen`

## Requirements
- R1: A write with `wr_hi`=0 stores `wr_byte` in divisor bits 7:0. A write with `wr_hi`=1 stores it in bits 15:8, so bit 7 of the high byte is divisor bit 15.
- R2: When divisor bit 15 is 0, the tick repeats every 4·N reference clocks, where N is divisor bits 14:0. This holds whatever the level of `hs_enable`.
- R3: When divisor bit 15 is 1 and `hs_enable` is 1, the tick repeats every N reference clocks. For example, 0x8001, 0x8002, 0x8003 and 0x8004 give periods of 1, 2, 3 and 4 clocks.
- R4: When divisor bit 15 is 1 and `hs_enable` is 0, the prescaler stays in use and the period is 4·N clocks.
- R5: When N is 0, `tick` stays low. This includes the state after reset, where the divisor resets to zero.
- R6: Any divisor write drives `tick` low in the cycle after the write. The first tick comes exactly one full new period after the write edge, with no leftover part of the old period.
- R7: When the period is 2 clocks or more, each tick is high for exactly one clock.
- R8: The largest ratio is 32767. Divisor 0x7FFF gives 131068 clocks, and 0xFFFF with `hs_enable`=1 gives 32767 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 7.3728 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Divisor byte write strobe |
| wr_hi | input | 1 | 0 selects the low divisor byte, 1 selects the high byte |
| wr_byte | input | 8 | Byte to write |
| hs_enable | input | 1 | High-speed enable from the mode register |
| tick | output | 1 | One-clock 16x oversampling enable |

## Verification
The hardest case to reach is a rewrite that lands partway through a long slow period. The bench programs a slow divisor, lets the prescaler and counter get partway through, and then writes a new value at an arbitrary cycle. It then checks that the first tick arrives exactly one new period later. The same latency check runs after every programmed divisor, including the two 15-bit extremes. Random divisor, prescaler-bit and enable combinations are mixed in, so that the two conditions for bypass are each exercised with the other one off.

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int          PRE_RATIO = 4,
  parameter logic [15:0] RST_DIV   = 16'h0000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_hi,
  input  logic [7:0] wr_byte,
  input  logic       hs_enable,
  output logic       tick
);
  localparam int DIV_W = 16;
  localparam int CNT_W = DIV_W - 1;
  localparam int PRE_W = $clog2(PRE_RATIO);

  logic [DIV_W-1:0] div_q, div_nxt;
  logic [CNT_W-1:0] ratio, ratio_nxt, cnt;
  logic [PRE_W-1:0] pre_cnt;
  logic             fast, pre_en, tick_q;

  assign div_nxt   = !wr_en ? div_q
                   : wr_hi  ? {wr_byte, div_q[7:0]}
                   :          {div_q[15:8], wr_byte};
  assign ratio     = div_q[CNT_W-1:0];
  assign ratio_nxt = div_nxt[CNT_W-1:0];
  assign fast      = div_q[DIV_W-1] & hs_enable;
  assign pre_en    = fast | (pre_cnt == PRE_W'(PRE_RATIO - 1));
  assign tick      = tick_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q   <= RST_DIV;
      pre_cnt <= '0;
      cnt     <= '0;
      tick_q  <= 1'b0;
    end else begin
      div_q <= div_nxt;
      if (wr_en || ratio == '0) begin
        pre_cnt <= '0;
        cnt     <= (ratio_nxt == '0) ? '0 : CNT_W'(ratio_nxt - 1'b1);
        tick_q  <= 1'b0;
      end else begin
        pre_cnt <= pre_en ? '0 : PRE_W'(pre_cnt + 1'b1);
        if (pre_en && cnt == '0) begin
          cnt    <= CNT_W'(ratio - 1'b1);
          tick_q <= 1'b1;
        end else begin
          if (pre_en) cnt <= CNT_W'(cnt - 1'b1);
          tick_q <= 1'b0;
        end
      end
    end
  end

  AST_HI_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_hi) |=> (div_q[15:8] == $past(wr_byte)));  // R1
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio != '0) |-> (cnt < ratio));  // R2
  AST_FAST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && fast && ratio == CNT_W'(1) && !wr_en) |=> tick);  // R3
  AST_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio == '0) |=> !tick);  // R5
  AST_WRITE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !tick);  // R6
  AST_SLOW_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !fast && !wr_en) |=> !tick);  // R7
endmodule

// File: tb/baud_tick_gen_bench.sv
module baud_tick_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_hi = 1'b0;
  logic [7:0] wr_byte = '0;
  logic       hs_enable = 1'b0;
  logic       tick;
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  baud_tick_gen u_baud_tick_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hi(wr_hi),
    .wr_byte(wr_byte), .hs_enable(hs_enable), .tick(tick)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int exp_period(logic [15:0] d, logic hs);
    return ((d[15] && hs) ? 1 : 4) * int'(d[14:0]);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_byte(logic hi, logic [7:0] b);
    wr_en = 1'b1; wr_hi = hi; wr_byte = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_tick(int limit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick && n <= limit);
  endtask

  task automatic measure(logic [15:0] d, logic hs, int extra, string req);
    int p, n;
    p = exp_period(d, hs);
    hs_enable = hs;
    write_byte(1'b0, d[7:0]);
    write_byte(1'b1, d[15:8]);
    check(tick == 1'b0, "R6 tick low after write", int'(tick), 0);
    wait_tick(p + 8, n);
    check(n == p, {req, " first tick after write"}, n, p);
    for (int i = 0; i < extra; i++) begin
      if (p >= 2) begin
        @(negedge clk);
        check(tick == 1'b0, "R7 single-cycle tick", int'(tick), 0);
        wait_tick(p + 8, n);
        check(n + 1 == p, {req, " tick period"}, n + 1, p);
      end else begin
        wait_tick(p + 8, n);
        check(n == p, {req, " tick period"}, n, p);
      end
    end
  endtask

  task automatic expect_silent(logic [15:0] d, logic hs, int span);
    int seen = 0;
    hs_enable = hs;
    write_byte(1'b0, d[7:0]);
    write_byte(1'b1, d[15:8]);
    for (int i = 0; i < span; i++) begin
      @(negedge clk);
      if (tick) seen++;
    end
    check(seen == 0, "R5 zero ratio gives no tick", seen, 0);
  endtask

  initial begin
    while (cyc < 199000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected < 199000", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic h;
    int seen;
    void'($urandom(32'h0BAD5EED));
    repeat (5) @(negedge clk);
    check(tick == 1'b0, "R5 reset state", int'(tick), 0);
    rst_n = 1'b1;
    seen = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (tick) seen++;
    end
    check(seen == 0, "R5 reset divisor silent", seen, 0);

    measure(16'h0001, 1'b0, 3, "R2");
    measure(16'h0001, 1'b1, 2, "R2");
    measure(16'h0006, 1'b1, 2, "R2");
    measure(16'h8001, 1'b1, 4, "R3");
    measure(16'h8002, 1'b1, 3, "R3");
    measure(16'h8003, 1'b1, 3, "R3");
    measure(16'h8004, 1'b1, 3, "R3");
    measure(16'h8001, 1'b0, 3, "R4");
    measure(16'h8004, 1'b0, 2, "R4");
    measure(16'h8105, 1'b1, 1, "R1");
    measure(16'h0203, 1'b0, 1, "R1");
    expect_silent(16'h8000, 1'b1, 300);
    expect_silent(16'h0000, 1'b0, 300);

    hs_enable = 1'b0;
    write_byte(1'b0, 8'h08);
    write_byte(1'b1, 8'h00);
    repeat (13) @(negedge clk);
    measure(16'h0005, 1'b0, 1, "R6");

    for (int t = 0; t < 10; t++) begin
      d = {1'($urandom), 15'(1 + ($urandom % 14))};
      h = 1'($urandom);
      measure(d, h, 2, (d[15] && h) ? "R3" : (d[15] ? "R4" : "R2"));
    end

    measure(16'hFFFF, 1'b1, 0, "R8");
    measure(16'h7FFF, 1'b0, 0, "R8");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule